// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache

This block is a read-only cache placed between a requester that issues 32-bit byte addresses and a slower lower-level memory. Every address is split into three fields: a byte offset within a block, a set index, and a tag. The index selects one set of two ways. Each way holds a valid bit, a tag and a block of 32-bit words. The two stored tags are compared against the address tag in the same cycle. A match returns the addressed word at once. A miss fetches the whole block from lower memory, installs it in one way, and then answers.

The requester side uses a valid/ready handshake with a one-cycle response pulse. The memory side sends a block-aligned request and receives the block back one word per beat, lowest word first. A parameter picks how the way to refill is chosen when both ways are occupied. One option keeps one history bit per set for least-recently-used replacement. The other uses the low bit of a free-running 16-bit LFSR. In both options an empty way is always filled first.

Top module: `rcache2w`

## Requirements
- R1: After reset every line is invalid, so the first access to any address misses even when a stored tag would compare equal. After reset req_ready is high, and rsp_valid and mem_req_valid are low.
- R2: The address splits as byte offset in bits [3:0], set index in bits [12:4] and tag in bits [31:13] for the default 16-byte block and 512 sets. The memory request carries the requested address with the offset bits cleared.
- R3: On a hit, rsp_valid rises in the cycle after the request is accepted, lasts one cycle, and no memory request is made. req_ready stays low while the response is shown.
- R4: The returned word is the word of the block selected by address bits [3:2]; for example, byte offset 0x4 returns the second word.
- R5: On a miss, exactly one memory request is issued and held until mem_req_ready. The block then arrives as 4 beats on mem_rsp_valid, carrying words 0 to 3 in that order, and idle cycles between beats are allowed. req_ready stays low until the response.
- R6: After a miss, the response carries the requested word of the fetched block. It comes one cycle after the cycle in which the last beat is accepted, and a later access to the same block hits.
- R7: When the indexed set has an invalid way, the miss fills that way and leaves the valid way untouched.
- R8: With LRU selection (USE_LRU=1), a miss on a full set replaces the way that was not hit or filled most recently.
- R9: With random selection (USE_LRU=0), a miss on a full set replaces one of the two ways chosen by a free-running LFSR, so over repeated trials either way can be evicted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Cache can accept a request |
| req_addr | input | 32 | Byte address of the read |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 32 | Word read |
| mem_req_valid | output | 1 | Block fetch request to lower memory |
| mem_req_ready | input | 1 | Lower memory accepts the fetch |
| mem_req_addr | output | 32 | Block-aligned fetch address |
| mem_rsp_valid | input | 1 | One word of the block is present |
| mem_rsp_data | input | 32 | Block word, lowest word first |

## Verification
A directed run follows one set through an empty miss, a hit on a neighbouring word, a tag-conflict miss into the still-empty way, and then misses that must evict. The expected victim tells invalid-first filling apart from LRU order. Constrained-random reads over four tags and eight sets mix hits with conflict misses, and random gaps between memory beats show whether beat ordering and the response cycle depend on the pacing of lower memory. A second instance in random mode is run through repeated three-tag conflicts on fresh sets. It must evict each way at least once, which separates an LFSR choice from a fixed way.

// File: rtl/rcache2w_pkg.sv
package rcache2w_pkg;
  localparam int ADDR_W = 32;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOK,
    ST_REQ,
    ST_FILL
  } ctl_st_t;
endpackage

// File: rtl/rcache2w_way.sv
module rcache2w_way #(
  parameter int SETS   = 512,
  parameter int IDX_W  = 9,
  parameter int WSEL_W = 2,
  parameter int TAG_W  = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [WSEL_W-1:0] rd_wsel,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [31:0]       rd_word,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WSEL_W-1:0] wr_wsel,
  input  logic              wr_data_en,
  input  logic [31:0]       wr_data,
  input  logic              wr_tag_en,
  input  logic [TAG_W-1:0]  wr_tag
);
  localparam int DEPTH = SETS << WSEL_W;

  logic [SETS-1:0]  vld_q;
  logic [TAG_W-1:0] tag_mem [SETS];
  logic [31:0]      dat_mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (wr_tag_en) begin
      vld_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_tag_en) begin
      tag_mem[wr_idx] <= wr_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_data_en) begin
      dat_mem[{wr_idx, wr_wsel}] <= wr_data;
    end
  end

  assign rd_valid = vld_q[rd_idx];
  assign rd_tag   = tag_mem[rd_idx];
  assign rd_word  = dat_mem[{rd_idx, rd_wsel}];
endmodule

// File: rtl/rcache2w_victim.sv
module rcache2w_victim #(
  parameter int SETS    = 512,
  parameter int IDX_W   = 9,
  parameter bit USE_LRU = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic             way0_valid,
  input  logic             way1_valid,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic             touch_way,
  output logic             victim
);
  logic policy_pick;

  generate
    if (USE_LRU) begin : g_lru
      logic [SETS-1:0] recent_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          recent_q <= '0;
        end else if (touch_en) begin
          recent_q[touch_idx] <= touch_way;
        end
      end
      assign policy_pick = ~recent_q[idx];
    end else begin : g_rand
      logic [15:0] lfsr_q;
      logic        fb;
      logic        unused_touch;
      assign fb = lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lfsr_q <= 16'hACE1;
        end else begin
          lfsr_q <= {lfsr_q[14:0], fb};
        end
      end
      assign policy_pick  = lfsr_q[0];
      assign unused_touch = ^{touch_en, touch_idx, touch_way};
    end
  endgenerate

  always_comb begin
    if (!way0_valid) begin
      victim = 1'b0;
    end else if (!way1_valid) begin
      victim = 1'b1;
    end else begin
      victim = policy_pick;
    end
  end
endmodule

// File: rtl/rcache2w.sv
module rcache2w #(
  parameter int BLOCK_BYTES = 16,
  parameter int SETS        = 512,
  parameter bit USE_LRU     = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_addr,
  output logic        rsp_valid,
  output logic [31:0] rsp_data,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data
);
  import rcache2w_pkg::*;

  localparam int OFS_W  = $clog2(BLOCK_BYTES);
  localparam int WORDS  = BLOCK_BYTES / 4;
  localparam int WSEL_W = $clog2(WORDS);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFS_W - IDX_W;
  localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(WORDS - 1);

  ctl_st_t            st_q, st_d;
  logic [ADDR_W-1:0]  addr_q;
  logic               vict_q;
  logic [WSEL_W-1:0]  beat_q;
  logic               accept;
  logic               beat_take;

  logic [TAG_W-1:0]   tag_f;
  logic [IDX_W-1:0]   idx_f;
  logic [WSEL_W-1:0]  wsel_f;
  logic               unused_lsb;

  logic [1:0]         way_vld;
  logic [TAG_W-1:0]   way_tag [2];
  logic [31:0]        way_word [2];
  logic [1:0]         match;
  logic               hit;
  logic [1:0]         fill_we;
  logic [1:0]         tag_we;
  logic               vict_pick;

  assign tag_f      = addr_q[ADDR_W-1 -: TAG_W];
  assign idx_f      = addr_q[OFS_W +: IDX_W];
  assign wsel_f     = addr_q[2 +: WSEL_W];
  assign unused_lsb = ^addr_q[1:0];

  assign accept    = req_valid && req_ready;
  assign beat_take = (st_q == ST_FILL) && mem_rsp_valid;

  generate
    for (genvar w = 0; w < 2; w++) begin : g_way
      assign fill_we[w] = beat_take && (vict_q == w[0]);
      assign tag_we[w]  = fill_we[w] && (beat_q == LAST_BEAT);
      assign match[w]   = way_vld[w] && (way_tag[w] == tag_f);

      rcache2w_way #(
        .SETS  (SETS),
        .IDX_W (IDX_W),
        .WSEL_W(WSEL_W),
        .TAG_W (TAG_W)
      ) u_way (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (idx_f),
        .rd_wsel   (wsel_f),
        .rd_valid  (way_vld[w]),
        .rd_tag    (way_tag[w]),
        .rd_word   (way_word[w]),
        .wr_idx    (idx_f),
        .wr_wsel   (beat_q),
        .wr_data_en(fill_we[w]),
        .wr_data   (mem_rsp_data),
        .wr_tag_en (tag_we[w]),
        .wr_tag    (tag_f)
      );
    end
  endgenerate

  assign hit = |match;

  rcache2w_victim #(
    .SETS   (SETS),
    .IDX_W  (IDX_W),
    .USE_LRU(USE_LRU)
  ) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx       (idx_f),
    .way0_valid(way_vld[0]),
    .way1_valid(way_vld[1]),
    .touch_en  ((st_q == ST_LOOK) && hit),
    .touch_idx (idx_f),
    .touch_way (match[1]),
    .victim    (vict_pick)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept)                                st_d = ST_LOOK;
      ST_LOOK: st_d = hit ? ST_IDLE : ST_REQ;
      ST_REQ:  if (mem_req_ready)                         st_d = ST_FILL;
      ST_FILL: if (mem_rsp_valid && beat_q == LAST_BEAT)  st_d = ST_LOOK;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      vict_q <= 1'b0;
      beat_q <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        addr_q <= req_addr;
      end
      if ((st_q == ST_LOOK) && !hit) begin
        vict_q <= vict_pick;
      end
      if (st_q == ST_REQ) begin
        beat_q <= '0;
      end else if (beat_take) begin
        beat_q <= beat_q + 1'b1;
      end
    end
  end

  assign req_ready     = (st_q == ST_IDLE);
  assign rsp_valid     = (st_q == ST_LOOK) && hit;
  assign rsp_data      = match[1] ? way_word[1] : way_word[0];
  assign mem_req_valid = (st_q == ST_REQ);
  assign mem_req_addr  = {addr_q[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
endmodule

// File: rtl/rcache2w_chk.sv
module rcache2w_chk #(
  parameter int OFS_W = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_req_addr,
  input logic        mem_rsp_valid,
  input logic [1:0]  fill_we,
  input logic [1:0]  tag_we
);
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);                                   // R5
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);                                                // R3
  AST_RSP_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);                                                // R3
  AST_MEMREQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R5
  AST_MEMREQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[OFS_W-1:0] == '0);                         // R2
  AST_IDLE_NO_MEMREQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid);                                            // R5
  AST_SINGLE_WAY_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fill_we));                                                       // R7
  AST_FILL_ON_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (|fill_we) |-> mem_rsp_valid);                                            // R5
  AST_RSP_AFTER_LAST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (|tag_we) |=> rsp_valid);                                                 // R6
endmodule

bind rcache2w rcache2w_chk #(.OFS_W(OFS_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .rsp_valid    (rsp_valid),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_addr (mem_req_addr),
  .mem_rsp_valid(mem_rsp_valid),
  .fill_we      (fill_we),
  .tag_we       (tag_we)
);

// File: tb/rcache2w_tb_top.sv
`timescale 1ns/1ps
module rcache2w_tb_top;
  localparam int SETS  = 512;
  localparam int WORDS = 4;

  logic clk;
  logic rst_n;
  logic [31:0] req_addr;
  logic rv_a, rv_b, mrr;
  logic rdy_a, rsv_a, mrv_a, msv_a;
  logic rdy_b, rsv_b, mrv_b, msv_b;
  logic [31:0] rd_a, mra_a, msd_a, rd_b, mra_b, msd_b;

  int nchk = 0;
  int nerr = 0;
  int nreq_a = 0, nreq_b = 0;
  int pend_a = 0, pend_b = 0;
  logic [31:0] base_a, base_b;

  bit          rf_v [2][SETS];
  logic [18:0] rf_t [2][SETS];
  bit          rf_l [SETS];

  initial clk = 1'b0;
  always #4 clk = ~clk;

  rcache2w #(.USE_LRU(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(rv_a), .req_ready(rdy_a), .req_addr(req_addr),
    .rsp_valid(rsv_a), .rsp_data(rd_a), .mem_req_valid(mrv_a), .mem_req_ready(mrr),
    .mem_req_addr(mra_a), .mem_rsp_valid(msv_a), .mem_rsp_data(msd_a));

  rcache2w #(.USE_LRU(1'b0)) dut_rnd (
    .clk(clk), .rst_n(rst_n), .req_valid(rv_b), .req_ready(rdy_b), .req_addr(req_addr),
    .rsp_valid(rsv_b), .rsp_data(rd_b), .mem_req_valid(mrv_b), .mem_req_ready(mrr),
    .mem_req_addr(mra_b), .mem_rsp_valid(msv_b), .mem_rsp_data(msd_b));

  function automatic logic [31:0] memfn(input logic [31:0] a);
    logic [31:0] w;
    w = {a[31:2], 2'b00};
    return (w * 32'h9E3779B1) ^ 32'h5A5A1234 ^ (w >> 7);
  endfunction

  // lower-memory models: beats start the cycle after the request, random gaps
  always @(negedge clk) begin
    msv_a = 1'b0;
    if (!rst_n) pend_a = 0;
    else begin
      if (pend_a > 0 && ($urandom % 4) != 0) begin
        msv_a = 1'b1;
        msd_a = memfn(base_a + 32'((WORDS - pend_a) * 4));
        pend_a--;
      end
      if (mrv_a) begin base_a = mra_a; pend_a = WORDS; nreq_a++; end
    end
  end

  always @(negedge clk) begin
    msv_b = 1'b0;
    if (!rst_n) pend_b = 0;
    else begin
      if (pend_b > 0 && ($urandom % 4) != 0) begin
        msv_b = 1'b1;
        msd_b = memfn(base_b + 32'((WORDS - pend_b) * 4));
        pend_b--;
      end
      if (mrv_b) begin base_b = mra_b; pend_b = WORDS; nreq_b++; end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic xfer(input bit sel, input logic [31:0] a, output logic [31:0] data,
                      output int lat, output int nreq, output logic [31:0] maddr,
                      output bit busy_ok, output bit pulse_ok);
    int n0;
    @(negedge clk);
    req_addr = a;
    if (sel) rv_b = 1'b1; else rv_a = 1'b1;
    while (!(sel ? rdy_b : rdy_a)) @(negedge clk);
    n0 = sel ? nreq_b : nreq_a;
    @(negedge clk);
    rv_a = 1'b0; rv_b = 1'b0;
    lat = 1; busy_ok = 1'b1;
    forever begin
      if (sel ? rsv_b : rsv_a) break;
      if (sel ? rdy_b : rdy_a) busy_ok = 1'b0;
      lat++;
      if (lat > 300) break;
      @(negedge clk);
    end
    data  = sel ? rd_b : rd_a;
    nreq  = (sel ? nreq_b : nreq_a) - n0;
    maddr = sel ? base_b : base_a;
    @(negedge clk);
    pulse_ok = !(sel ? rsv_b : rsv_a);
  endtask

  // LRU instance access against the reference model
  task automatic acc(input logic [31:0] a, input string vtag);
    logic [31:0] d, ma;
    int lat, nr;
    bit bo, po, eh;
    bit hw, v;
    logic [8:0]  ix;
    logic [18:0] tg;
    ix = a[12:4];
    tg = a[31:13];
    eh = 1'b0; hw = 1'b0;
    for (int w = 0; w < 2; w++)
      if (rf_v[w][ix] && rf_t[w][ix] == tg) begin eh = 1'b1; hw = w[0]; end
    xfer(1'b0, a, d, lat, nr, ma, bo, po);
    chk(d == memfn(a), eh ? "R4" : "R6", "returned word", d, memfn(a));
    chk(po, "R3", "response is one cycle", 32'(po), 32'd1);
    if (eh) begin
      chk(nr == 0, vtag, "hit expected, memory requests", 32'(nr), 32'd0);
      chk(lat == 1, "R3", "hit latency", 32'(lat), 32'd1);
      rf_l[ix] = hw;
    end else begin
      chk(nr == 1, vtag, "miss expected, memory requests", 32'(nr), 32'd1);
      chk(ma == {a[31:4], 4'h0}, "R2", "block fetch address", ma, {a[31:4], 4'h0});
      chk(bo, "R5", "ready low during miss", 32'(bo), 32'd1);
      if (!rf_v[0][ix]) v = 1'b0;
      else if (!rf_v[1][ix]) v = 1'b1;
      else v = ~rf_l[ix];
      rf_v[v][ix] = 1'b1;
      rf_t[v][ix] = tg;
      rf_l[ix] = v;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [31:0] d, ma, a;
    int lat, nr, ev0, ev1;
    bit bo, po;
    void'($urandom(32'd7041));
    rst_n = 1'b0; rv_a = 1'b0; rv_b = 1'b0; mrr = 1'b1; req_addr = '0;
    for (int s = 0; s < SETS; s++) begin rf_v[0][s] = 0; rf_v[1][s] = 0; rf_l[s] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rdy_a == 1'b1, "R1", "req_ready after reset", 32'(rdy_a), 32'd1);
    chk(rsv_a == 1'b0, "R1", "rsp_valid after reset", 32'(rsv_a), 32'd0);
    chk(mrv_a == 1'b0, "R1", "mem_req_valid after reset", 32'(mrv_a), 32'd0);

    // directed walk through set 1
    acc(32'h0000_0000, "R1");
    acc(32'h0000_0014, "R1");
    acc(32'h0000_001C, "R3");
    acc(32'h0000_0010, "R4");
    acc(32'h0000_0034, "R5");
    acc(32'h0000_2014, "R7");
    acc(32'h0000_0018, "R7");
    acc(32'h0000_2010, "R6");
    acc(32'h0000_4014, "R8");
    acc(32'h0000_2018, "R8");
    acc(32'h0000_0014, "R8");
    acc(32'h0000_4014, "R8");
    acc(32'h0000_201C, "R8");

    // constrained random mix on four tags and eight sets
    for (int i = 0; i < 400; i++) begin
      a = (32'($urandom % 4) << 13) | (32'($urandom % 8) << 4) | 32'($urandom % 16);
      if (($urandom % 16) == 0) a = $urandom;
      acc(a, "R8");
    end

    // random-replacement instance: three tags conflict on a fresh set each trial
    ev0 = 0; ev1 = 0;
    for (int k = 0; k < 24; k++) begin
      a = 32'((k + 40) << 4);
      xfer(1'b1, a, d, lat, nr, ma, bo, po);
      chk(d == memfn(a), "R6", "random mode fill word", d, memfn(a));
      xfer(1'b1, a | 32'h2000, d, lat, nr, ma, bo, po);
      xfer(1'b1, a, d, lat, nr, ma, bo, po);
      chk(nr == 0, "R7", "random mode keeps valid way", 32'(nr), 32'd0);
      repeat ($urandom % 5) @(negedge clk);
      xfer(1'b1, a | 32'h4000, d, lat, nr, ma, bo, po);
      chk(nr == 1, "R9", "third tag misses", 32'(nr), 32'd1);
      xfer(1'b1, a | 32'h4 , d, lat, nr, ma, bo, po);
      chk(d == memfn(a | 32'h4), "R9", "random mode word", d, memfn(a | 32'h4));
      if (nr == 0) ev1++; else ev0++;
    end
    chk(ev0 > 0, "R9", "way holding first tag evicted at least once", 32'(ev0), 32'd1);
    chk(ev1 > 0, "R9", "way holding second tag evicted at least once", 32'(ev1), 32'd1);

    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule